// File: doc/BRIEF.md
# Interrupt Distributor Global Control Register Block

This block holds the global control state of an interrupt distributor and answers reads of its identification words. A bus master uses 32-bit word accesses. Byte address bits [3:2] pick one of four words: the control word, the primary type word, the secondary type word and the identification word. Any address with a nonzero bit above bit 3 is unimplemented. The type and identification words are built from elaboration parameters. Only the control word has writable state.

The control state is a four-state machine. The states are `ST_OFF_SW` (disabled, software SGIs), `ST_OFF_HW` (disabled, hardware SGIs requested), `ST_ON_SW` (enabled, software SGIs) and `ST_ON_HW` (enabled, hardware SGIs). A control write in either disabled state moves the machine straight to the state named by the written enable bit and the written SGI request bit. A control write in an enabled state follows one of two transitions:
- When the write keeps the enable bit set, the machine stays in its state and the SGI request bit is ignored.
- When the write clears the enable bit, the machine drops to `ST_OFF_SW` or `ST_OFF_HW` according to the written SGI request bit.

When the `HW_SGI` parameter is 0, the written SGI request bit is treated as zero, so the two `_HW` states are never reached.

The block does not touch the interrupt datapath. It reports control changes as one-cycle event pulses that a neighbouring block acts on:
- a reload pulse
- a CPU wake pulse
- an SGI reconfigure pulse

Top module: `dist_ctl_regs`

## Requirements
- R1: A read of word 0 (control) returns bit 4 and bit 6 set, bit 1 equal to the stored enable, bit 8 equal to the stored SGI mode, and all other bits zero. Read data appears on `rd_data` in the cycle after the request and holds until the next read.
- R2: A control write stores bit 1 of the write data as the enable, visible on `dist_enabled` and in later control reads.
- R3: With `HW_SGI`=0, bit 8 of a control write is treated as 0, so the stored SGI mode stays 0.
- R4: When the distributor is enabled before a control write and bit 1 of that write is 1, the stored SGI mode keeps its old value. In every other case the stored SGI mode takes the (possibly forced) bit 8.
- R5: Bits [4:0] of word 1 (type) equal (32 + `NUM_SHARED`)/32 - 1.
- R6: Bits [23:19] of word 1 equal the ID width minus one. The ID width is `ID_BITS_MSI` when `MSI_EN`=1 and `ID_BITS_PLAIN` otherwise. Bit 17 of word 1 is set only when `MSI_EN`=1. Writes to word 1 have no effect.
- R7: Word 2 (secondary type) reads bit 8 set when `HW_SGI`=1, and reads zero otherwise.
- R8: Word 3 (identification) reads `PRODUCT_ID` in bits [31:24], `IMPL_REV` in bits [15:12], `IMPLEMENTER` in bits [11:0], and zero elsewhere.
- R9: With `HW_SGI`=1, a control write that changes the enable raises `reload_pulse` for exactly one cycle, in the cycle after the write.
- R10: With `HW_SGI`=0, a control write that takes the enable from 0 to 1 raises `wake_pulse` for one cycle after the write. Clearing the enable raises no pulse.
- R11: A control write that changes the stored SGI mode raises `sgi_reconfig_pulse` for one cycle after the write.
- R12: Reads of unimplemented addresses return zero, and writes to them change no state and raise no pulse.
- R13: After reset the block is in `ST_OFF_SW`, every pulse is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| dist_enabled | output | 1 | Stored enable state |
| sgi_hw_mode | output | 1 | Stored SGI mode |
| reload_pulse | output | 1 | Enable changed (hardware SGI build) |
| wake_pulse | output | 1 | Enable rose (software SGI build) |
| sgi_reconfig_pulse | output | 1 | SGI mode changed |

## Verification
The control word is exercised with write patterns that do the following:
- enable and request hardware SGIs together
- keep the enable set while trying to drop the SGI request
- disable while dropping the SGI request
- set the SGI request while staying disabled
- enable from a state that holds a stale SGI request

Together these patterns separate the hold-while-enabled rule from the take-when-toggling rule, and they show which pulse each change produces. A second instance, built without hardware SGIs and with message interrupts enabled, shows the forced-zero request, the wake-only-on-rise behaviour and the alternative type word. Writes to the type word and to unimplemented offsets are followed by reads that show nothing moved.

// File: rtl/dist_ctl_pkg.sv
`timescale 1ns/1ps
package dist_ctl_pkg;
    // {enable, sgi_mode} encoding of the control state
    typedef enum logic [1:0] {
        ST_OFF_SW = 2'b00,
        ST_OFF_HW = 2'b01,
        ST_ON_SW  = 2'b10,
        ST_ON_HW  = 2'b11
    } dist_mode_e;

    localparam int BIT_EN    = 1;
    localparam int BIT_AFF   = 4;
    localparam int BIT_NOSEC = 6;
    localparam int BIT_SGI   = 8;

    localparam int TYP_ID_LSB   = 19;
    localparam int TYP_LPI      = 17;
    localparam int TYP2_CAP     = 8;
    localparam int IDN_PROD_LSB = 24;
    localparam int IDN_REV_LSB  = 12;

    localparam logic [1:0] W_CTRL  = 2'd0;
    localparam logic [1:0] W_TYPE  = 2'd1;
    localparam logic [1:0] W_TYPE2 = 2'd2;
    localparam logic [1:0] W_IDENT = 2'd3;
endpackage

// File: rtl/dist_ctl_fsm.sv
`timescale 1ns/1ps
module dist_ctl_fsm
    import dist_ctl_pkg::*;
#(
    parameter bit HW_SGI = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_en_bit,
    input  logic wr_sgi_bit,
    output logic enabled,
    output logic sgi_mode,
    output logic reload_pulse,
    output logic wake_pulse,
    output logic reconfig_pulse
);
    dist_mode_e state, nxt;
    logic       req_sgi;

    generate
        if (HW_SGI) begin : g_hw
            assign req_sgi = wr_sgi_bit;
        end else begin : g_nohw
            logic unused_sgi;
            assign unused_sgi = wr_sgi_bit;
            assign req_sgi    = 1'b0;
        end
    endgenerate

    // next-state: disabled states take the written pair, enabled states hold SGI mode
    always_comb begin
        nxt = state;
        if (ctl_wr) begin
            unique case (state)
                ST_OFF_SW, ST_OFF_HW: nxt = dist_mode_e'({wr_en_bit, req_sgi});
                ST_ON_SW: nxt = wr_en_bit ? ST_ON_SW : (req_sgi ? ST_OFF_HW : ST_OFF_SW);
                ST_ON_HW: nxt = wr_en_bit ? ST_ON_HW : (req_sgi ? ST_OFF_HW : ST_OFF_SW);
                default:  nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF_SW;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_OFF_SW: begin enabled = 1'b0; sgi_mode = 1'b0; end
            ST_OFF_HW: begin enabled = 1'b0; sgi_mode = 1'b1; end
            ST_ON_SW:  begin enabled = 1'b1; sgi_mode = 1'b0; end
            ST_ON_HW:  begin enabled = 1'b1; sgi_mode = 1'b1; end
            default:   begin enabled = 1'b0; sgi_mode = 1'b0; end
        endcase
    end

    // event outputs, one cycle after the write that caused them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_pulse   <= 1'b0;
            wake_pulse     <= 1'b0;
            reconfig_pulse <= 1'b0;
        end else begin
            reload_pulse   <= HW_SGI && (state[1] != nxt[1]);
            wake_pulse     <= !HW_SGI && !state[1] && nxt[1];
            reconfig_pulse <= state[0] != nxt[0];
        end
    end

    assert_hold_sgi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && $past(enabled)) |-> $stable(sgi_mode));
    assert_reconf_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig_pulse |-> (sgi_mode != $past(sgi_mode)));
    assert_reload_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> (enabled != $past(enabled)));
    assert_wake_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (enabled && !$past(enabled)));
    assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reload_pulse, wake_pulse}));

    generate
        if (!HW_SGI) begin : g_chk_nohw
            assert_sgi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !sgi_mode && !reload_pulse);
        end
    endgenerate
endmodule

// File: rtl/dist_ctl_idwords.sv
`timescale 1ns/1ps
module dist_ctl_idwords
    import dist_ctl_pkg::*;
#(
    parameter int          NUM_SHARED    = 224,
    parameter bit          MSI_EN        = 1'b0,
    parameter int          ID_BITS_PLAIN = 10,
    parameter int          ID_BITS_MSI   = 16,
    parameter bit          HW_SGI        = 1'b1,
    parameter logic [7:0]  PRODUCT_ID    = 8'h4B,
    parameter logic [3:0]  IMPL_REV      = 4'd3,
    parameter logic [11:0] IMPLEMENTER   = 12'h43B
) (
    output logic [31:0] type_word,
    output logic [31:0] type2_word,
    output logic [31:0] ident_word
);
    localparam int TOTAL_LINES = 32 + NUM_SHARED;
    localparam int LINE_FIELD  = TOTAL_LINES / 32 - 1;
    localparam int ID_BITS     = MSI_EN ? ID_BITS_MSI : ID_BITS_PLAIN;

    logic [31:0] base_type;
    assign base_type = {27'd0, 5'(LINE_FIELD)} | ({27'd0, 5'(ID_BITS - 1)} << TYP_ID_LSB);

    generate
        if (MSI_EN) begin : g_msi
            assign type_word = base_type | (32'd1 << TYP_LPI);
        end else begin : g_plain
            assign type_word = base_type;
        end
        if (HW_SGI) begin : g_cap
            assign type2_word = 32'd1 << TYP2_CAP;
        end else begin : g_nocap
            assign type2_word = 32'd0;
        end
    endgenerate

    assign ident_word = ({24'd0, PRODUCT_ID} << IDN_PROD_LSB)
                      | ({28'd0, IMPL_REV} << IDN_REV_LSB)
                      | {20'd0, IMPLEMENTER};
endmodule

// File: rtl/dist_ctl_rdmux.sv
`timescale 1ns/1ps
module dist_ctl_rdmux
    import dist_ctl_pkg::*;
(
    input  logic        implemented,
    input  logic [1:0]  word_sel,
    input  logic        enabled,
    input  logic        sgi_mode,
    input  logic [31:0] type_word,
    input  logic [31:0] type2_word,
    input  logic [31:0] ident_word,
    output logic [31:0] rdata
);
    logic [31:0] ctrl_word;

    always_comb begin
        ctrl_word            = 32'd0;
        ctrl_word[BIT_EN]    = enabled;
        ctrl_word[BIT_AFF]   = 1'b1;
        ctrl_word[BIT_NOSEC] = 1'b1;
        ctrl_word[BIT_SGI]   = sgi_mode;
    end

    always_comb begin
        rdata = 32'd0;
        if (implemented) begin
            unique case (word_sel)
                W_CTRL:  rdata = ctrl_word;
                W_TYPE:  rdata = type_word;
                W_TYPE2: rdata = type2_word;
                W_IDENT: rdata = ident_word;
                default: rdata = 32'd0;
            endcase
        end
    end
endmodule

// File: rtl/dist_ctl_regs.sv
`timescale 1ns/1ps
module dist_ctl_regs
    import dist_ctl_pkg::*;
#(
    parameter int          ADDR_W        = 6,
    parameter int          NUM_SHARED    = 224,
    parameter bit          MSI_EN        = 1'b0,
    parameter int          ID_BITS_PLAIN = 10,
    parameter int          ID_BITS_MSI   = 16,
    parameter bit          HW_SGI        = 1'b1,
    parameter logic [7:0]  PRODUCT_ID    = 8'h4B,
    parameter logic [3:0]  IMPL_REV      = 4'd3,
    parameter logic [11:0] IMPLEMENTER   = 12'h43B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              dist_enabled,
    output logic              sgi_hw_mode,
    output logic              reload_pulse,
    output logic              wake_pulse,
    output logic              sgi_reconfig_pulse
);
    localparam int HI_W = ADDR_W - 4;

    logic        implemented, ctl_wr, rd_fire;
    logic [1:0]  word_sel;
    logic [31:0] type_word, type2_word, ident_word, rdata_c;
    logic        unused_bits;

    assign implemented = (req_addr[ADDR_W-1:4] == HI_W'(0));
    assign word_sel    = req_addr[3:2];
    assign ctl_wr      = req_valid && req_write && implemented && (word_sel == W_CTRL);
    assign rd_fire     = req_valid && !req_write;
    assign unused_bits = ^{req_addr[1:0], req_wdata[31:9], req_wdata[7:2], req_wdata[0]};

    dist_ctl_fsm #(.HW_SGI(HW_SGI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .wr_en_bit(req_wdata[BIT_EN]), .wr_sgi_bit(req_wdata[BIT_SGI]),
        .enabled(dist_enabled), .sgi_mode(sgi_hw_mode),
        .reload_pulse(reload_pulse), .wake_pulse(wake_pulse),
        .reconfig_pulse(sgi_reconfig_pulse)
    );

    dist_ctl_idwords #(
        .NUM_SHARED(NUM_SHARED), .MSI_EN(MSI_EN), .ID_BITS_PLAIN(ID_BITS_PLAIN),
        .ID_BITS_MSI(ID_BITS_MSI), .HW_SGI(HW_SGI), .PRODUCT_ID(PRODUCT_ID),
        .IMPL_REV(IMPL_REV), .IMPLEMENTER(IMPLEMENTER)
    ) u_ids (
        .type_word(type_word), .type2_word(type2_word), .ident_word(ident_word)
    );

    dist_ctl_rdmux u_rdmux (
        .implemented(implemented), .word_sel(word_sel),
        .enabled(dist_enabled), .sgi_mode(sgi_hw_mode),
        .type_word(type_word), .type2_word(type2_word), .ident_word(ident_word),
        .rdata(rdata_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= 32'd0;
        else if (rd_fire) rd_data <= rdata_c;
    end

    assert_unimpl_wi_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !implemented) |=>
            ($stable(dist_enabled) && $stable(sgi_hw_mode) && !sgi_reconfig_pulse));
    assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rd_data));
endmodule

// File: tb/dist_ctl_regs_bench.sv
`timescale 1ns/1ps
module dist_ctl_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        a_valid = 0, a_write = 0;
    logic [5:0]  a_addr = 0;
    logic [31:0] a_wdata = 0, a_rd;
    logic        a_en, a_sgi, a_reload, a_wake, a_reconf;

    logic        b_valid = 0, b_write = 0;
    logic [5:0]  b_addr = 0;
    logic [31:0] b_wdata = 0, b_rd;
    logic        b_en, b_sgi, b_reload, b_wake, b_reconf;

    int checks = 0;
    int errors = 0;

    dist_ctl_regs u_dist_ctl_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_write(a_write),
        .req_addr(a_addr), .req_wdata(a_wdata), .rd_data(a_rd),
        .dist_enabled(a_en), .sgi_hw_mode(a_sgi), .reload_pulse(a_reload),
        .wake_pulse(a_wake), .sgi_reconfig_pulse(a_reconf)
    );

    dist_ctl_regs #(.NUM_SHARED(96), .MSI_EN(1'b1), .HW_SGI(1'b0)) u_dist_ctl_regs_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_write(b_write),
        .req_addr(b_addr), .req_wdata(b_wdata), .rd_data(b_rd),
        .dist_enabled(b_en), .sgi_hw_mode(b_sgi), .reload_pulse(b_reload),
        .wake_pulse(b_wake), .sgi_reconfig_pulse(b_reconf)
    );

    // {write, addr, wdata, expected read, expected {reload, wake, reconfig}}
    localparam logic [73:0] VEC [20] = '{
        {1'b0, 6'h00, 32'h0,        32'h00000050, 3'b000}, // R1 reset control
        {1'b0, 6'h04, 32'h0,        32'h00480007, 3'b000}, // R5 R6 type
        {1'b0, 6'h08, 32'h0,        32'h00000100, 3'b000}, // R7
        {1'b0, 6'h0C, 32'h0,        32'h4B00343B, 3'b000}, // R8
        {1'b1, 6'h00, 32'h00000102, 32'h0,        3'b101}, // enable + SGI: R9 R11
        {1'b0, 6'h00, 32'h0,        32'h00000152, 3'b000}, // R2
        {1'b1, 6'h00, 32'h00000002, 32'h0,        3'b000}, // stay enabled, SGI held R4
        {1'b0, 6'h00, 32'h0,        32'h00000152, 3'b000}, // R4
        {1'b1, 6'h00, 32'h00000000, 32'h0,        3'b101}, // disable, SGI taken R4
        {1'b0, 6'h00, 32'h0,        32'h00000050, 3'b000},
        {1'b1, 6'h00, 32'h00000100, 32'h0,        3'b001}, // SGI while off R11
        {1'b0, 6'h00, 32'h0,        32'h00000150, 3'b000},
        {1'b1, 6'h10, 32'h00000002, 32'h0,        3'b000}, // unimplemented write R12
        {1'b0, 6'h00, 32'h0,        32'h00000150, 3'b000}, // R12 unchanged
        {1'b0, 6'h10, 32'h0,        32'h00000000, 3'b000}, // R12
        {1'b0, 6'h3C, 32'h0,        32'h00000000, 3'b000}, // R12
        {1'b1, 6'h04, 32'hFFFFFFFF, 32'h0,        3'b000}, // type write R6
        {1'b0, 6'h04, 32'h0,        32'h00480007, 3'b000},
        {1'b1, 6'h00, 32'h00000002, 32'h0,        3'b101}, // enable drops stale SGI R4
        {1'b0, 6'h00, 32'h0,        32'h00000052, 3'b000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access_a(input logic w, input logic [5:0] ad, input logic [31:0] d);
        a_valid = 1'b1; a_write = w; a_addr = ad; a_wdata = d;
        @(negedge clk);
        a_valid = 1'b0; a_write = 1'b0;
    endtask

    task automatic access_b(input logic w, input logic [5:0] ad, input logic [31:0] d);
        b_valid = 1'b1; b_write = w; b_addr = ad; b_wdata = d;
        @(negedge clk);
        b_valid = 1'b0; b_write = 1'b0;
    endtask

    function automatic string tag_of(input logic w, input logic [5:0] ad);
        if (w) return "R9_R11_pulses";
        case (ad)
            6'h00:   return "R1";
            6'h04:   return "R5";
            6'h08:   return "R7";
            6'h0C:   return "R8";
            default: return "R12";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 rd_data", a_rd, 32'h0);
        chk("R13 pulses", {29'd0, a_reload, a_wake, a_reconf}, 32'h0);
        chk("R13 state", {30'd0, a_en, a_sgi}, 32'h0);

        for (int i = 0; i < 20; i++) begin
            logic [73:0] v;
            v = VEC[i];
            access_a(v[73], v[72:67], v[66:35]);
            if (v[73])
                chk(tag_of(1'b1, v[72:67]), {29'd0, a_reload, a_wake, a_reconf}, {29'd0, v[2:0]});
            else
                chk(tag_of(1'b0, v[72:67]), a_rd, v[34:3]);
        end
        chk("R2 dist_enabled", {31'd0, a_en}, 32'd1);

        // R9: pulse lasts one cycle only
        access_a(1'b1, 6'h00, 32'h0);
        chk("R9 reload rise", {31'd0, a_reload}, 32'd1);
        @(negedge clk);
        chk("R9 reload one cycle", {31'd0, a_reload}, 32'd0);

        // second instance: no hardware SGI, message interrupts on
        access_b(1'b0, 6'h00, 32'h0);
        chk("R13 b control", b_rd, 32'h00000050);
        access_b(1'b0, 6'h04, 32'h0);
        chk("R6 b type", b_rd, 32'h007A0003);
        access_b(1'b0, 6'h08, 32'h0);
        chk("R7 b type2", b_rd, 32'h0);
        access_b(1'b1, 6'h00, 32'h00000102);
        chk("R10 wake on rise", {29'd0, b_reload, b_wake, b_reconf}, 32'b010);
        @(negedge clk);
        chk("R10 wake one cycle", {31'd0, b_wake}, 32'd0);
        access_b(1'b0, 6'h00, 32'h0);
        chk("R3 forced zero", b_rd, 32'h00000052);
        access_b(1'b1, 6'h20, 32'h0);
        access_b(1'b0, 6'h00, 32'h0);
        chk("R12 b unimpl write", b_rd, 32'h00000052);
        access_b(1'b1, 6'h00, 32'h00000100);
        chk("R10 no pulse on clear", {29'd0, b_reload, b_wake, b_reconf}, 32'b000);
        access_b(1'b0, 6'h00, 32'h0);
        chk("R3 disabled still zero", b_rd, 32'h00000050);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule